// File: doc/BRIEF.md
# Wakeup Frame Pattern Matcher

This block watches the bytes of each received frame and decides, at the frame's last byte, whether the frame matches any of five programmable wakeup patterns. Each pattern keeps a byte mask and an expected 16-bit check value. While the frame streams in, every pattern folds the bytes its mask selects into its own CRC. At the end of the frame, each enabled pattern compares its CRC with the stored value. Two patterns are short and can only select from the first 64 byte offsets. The other three are long and can select from the first 128 offsets. All five run side by side in a single pass over the frame.

The receive path presents the bytes on a simple strobe interface. Each accepted byte has a valid strobe. The first byte of a frame carries a start flag and the last byte carries an end flag. Masks and check values are loaded through a 32-bit register write port. The result is a hit vector that holds one bit per pattern, plus a single-cycle wake pulse that power management logic can use.

Top module: `wake_pattern_matcher`

## Requirements
- R1: After reset, `hit_vec` and `wake_pulse` are 0, and every mask and check value is 0, so no pattern can match until it is programmed.
- R2: A write with `cfg_we` high selects the pattern with `cfg_addr[5:3]` (0 and 1 are short, 2 to 4 are long). Word `cfg_addr[2:0]` = 0..3 loads mask bits [32w+31:32w], and mask bit k selects frame byte offset k. Word 4 loads the check value from `cfg_wdata[15:0]`. Writes to words 5 to 7, to pattern indexes 5 to 7, and to words 2 and 3 of a short pattern have no effect.
- R3: A pattern's CRC starts at 0xFFFF with polynomial 0x8005. Each selected byte is shifted in MSB first, with no reflection and no final inversion. Bytes whose mask bit is 0 leave the CRC unchanged.
- R4: On the cycle after the end-of-frame byte is accepted, `hit_vec[p]` is 1 exactly when pattern p is enabled and its CRC, including that final byte, equals its check value. `hit_vec` then holds until the next start-of-frame byte.
- R5: `wake_pulse` is high for exactly the one cycle in which `hit_vec` is updated with at least one set bit. It is low at all other times.
- R6: A short pattern ignores every byte at offset 64 and beyond, and a long pattern ignores every byte at offset 128 and beyond.
- R7: A frame shorter than a pattern's coverage is evaluated over the bytes actually received. Mask bits at offsets past the frame's end have no effect.
- R8: A pattern whose mask is all zero is disabled and never sets its hit bit, even when its check value equals the initial CRC 0xFFFF.
- R9: A byte accepted with `in_sof` restarts every pattern's CRC at offset 0 and clears `hit_vec` unless it also ends the frame. Cycles with `in_valid` low, and valid bytes that arrive between an end-of-frame byte and the next start-of-frame byte, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_eof | input | 1 | The present byte is the last byte of a frame |
| in_data | input | 8 | Received byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Pattern index in [5:3], word index in [2:0] |
| cfg_wdata | input | 32 | Write data |
| hit_vec | output | 5 | Per-pattern match result of the most recent frame |
| wake_pulse | output | 1 | One-cycle pulse when any pattern matched |

## Verification
Random frames of 1 to 200 bytes run against random sparse masks. For some patterns the check value is programmed to the CRC the frame will produce, so hits and misses both occur, and any error in mask-bit ordering or CRC arithmetic shows up as a wrong hit bit. Directed frames separate the special cases. An all-zero mask paired with check value 0xFFFF tells a disabled pattern apart from an empty match. Frames longer than 64 and 128 bytes show whether coverage stops at the right offset. A 10-byte frame with mask bits set past its end checks early evaluation. Idle cycles, stray bytes between frames and writes to unused addresses must leave the hit vector and later results unchanged.

// File: rtl/wake_pattern_matcher.sv
module wake_pattern_matcher #(
  parameter int NUM_SHORT = 2,
  parameter int NUM_LONG  = 3,
  parameter int SHORT_LEN = 64,
  parameter int LONG_LEN  = 128,
  parameter int CRC_W     = 16,
  parameter logic [15:0] CRC_POLY = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter int CFG_AW    = 6,
  parameter int CFG_DW    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic                             in_sof,
  input  logic                             in_eof,
  input  logic [7:0]                       in_data,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [CFG_DW-1:0]                cfg_wdata,
  output logic [NUM_SHORT+NUM_LONG-1:0]    hit_vec,
  output logic                             wake_pulse
);
  localparam int NP     = NUM_SHORT + NUM_LONG;
  localparam int OFF_W  = $clog2(LONG_LEN + 1);
  localparam int WORDS  = LONG_LEN / CFG_DW;
  localparam int WSEL_W = $clog2(WORDS + 1);
  localparam int PSEL_W = CFG_AW - WSEL_W;

  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c, input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY[CRC_W-1:0];
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction

  logic             in_frame_q;
  logic [OFF_W-1:0] off_q;
  logic [NP-1:0]    pat_en;
  logic [NP-1:0]    match;

  wire              take    = in_valid && (in_sof || in_frame_q);
  wire [OFF_W-1:0]  cur_off = in_sof ? '0 : off_q;
  wire [PSEL_W-1:0] cfg_pat = cfg_addr[CFG_AW-1:WSEL_W];
  wire [WSEL_W-1:0] cfg_wrd = cfg_addr[WSEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      off_q      <= '0;
    end else if (take) begin
      in_frame_q <= !in_eof;
      off_q      <= (cur_off == OFF_W'(LONG_LEN)) ? cur_off : cur_off + 1'b1;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_pat
    localparam int PLEN   = (p < NUM_SHORT) ? SHORT_LEN : LONG_LEN;
    localparam int PWORDS = PLEN / CFG_DW;
    localparam int PIDX_W = $clog2(PLEN);

    logic [PLEN-1:0]  mask_q;
    logic [CRC_W-1:0] exp_q;
    logic [CRC_W-1:0] crc_q;
    wire              sel_p    = cfg_we && (cfg_pat == PSEL_W'(p));
    wire              use_b    = (cur_off < OFF_W'(PLEN)) && mask_q[cur_off[PIDX_W-1:0]];
    wire [CRC_W-1:0]  crc_base = in_sof ? CRC_INIT[CRC_W-1:0] : crc_q;
    wire [CRC_W-1:0]  crc_nxt  = use_b ? crc_byte(crc_base, in_data) : crc_base;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        exp_q  <= '0;
      end else if (sel_p) begin
        for (int w = 0; w < PWORDS; w++)
          if (cfg_wrd == WSEL_W'(w)) mask_q[w*CFG_DW +: CFG_DW] <= cfg_wdata;
        if (cfg_wrd == WSEL_W'(WORDS)) exp_q <= cfg_wdata[CRC_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '0;
      else if (take) crc_q <= crc_nxt;
    end

    assign pat_en[p] = |mask_q;
    assign match[p]  = pat_en[p] && (crc_nxt == exp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vec    <= '0;
      wake_pulse <= 1'b0;
    end else if (take && in_eof) begin
      hit_vec    <= match;
      wake_pulse <= |match;
    end else begin
      wake_pulse <= 1'b0;
      if (take && in_sof) hit_vec <= '0;
    end
  end
endmodule

module wpm_checker #(
  parameter int NP = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic          in_eof,
  input logic [NP-1:0] hit_vec,
  input logic          wake_pulse,
  input logic [NP-1:0] pat_en
);
  assert_wake_after_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(in_valid && in_eof));

  assert_wake_has_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (hit_vec != '0));

  assert_hits_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hit_vec));

  assert_disabled_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> ((hit_vec & ~$past(pat_en)) == '0));

  assert_sof_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eof) |=> (hit_vec == '0 && !wake_pulse));
endmodule

bind wake_pattern_matcher wpm_checker #(.NP(NP)) u_wpm_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .hit_vec(hit_vec), .wake_pulse(wake_pulse), .pat_en(pat_en)
);

// File: tb/tb_wake_pattern_matcher.sv
`timescale 1ns/1ps
module tb_wake_pattern_matcher;
  localparam int NP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NP-1:0] hit_vec;
  logic        wake_pulse;

  int checks = 0, failures = 0;

  logic [127:0] mm [NP];
  logic [15:0]  ee [NP];
  logic [7:0]   fr [256];

  always #2.5 clk = ~clk;

  wake_pattern_matcher dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hit_vec(hit_vec), .wake_pulse(wake_pulse)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int plen(input int p);
    return (p < 2) ? 64 : 128;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[15] ^ d[i]) ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  function automatic logic [15:0] ref_crc(input int p, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      if (i < plen(p) && mm[p][i]) c = step(c, fr[i]);
    return c;
  endfunction

  function automatic logic [NP-1:0] ref_hits(input int n);
    logic [NP-1:0] h;
    for (int p = 0; p < NP; p++) h[p] = (mm[p] != '0) && (ref_crc(p, n) == ee[p]);
    return h;
  endfunction

  task automatic wr(input int pat, input int wrd, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'((pat << 3) | wrd); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (pat < NP) begin
      if (wrd < 4 && !(pat < 2 && wrd >= 2)) mm[pat][wrd*32 +: 32] = d;
      else if (wrd == 4) ee[pat] = d[15:0];
    end
  endtask

  task automatic idle_noise();
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'($urandom);
    in_sof = 1'($urandom); in_eof = 1'($urandom);
  endtask

  task automatic send_frame(input int n, input bit gaps, input string tag);
    logic [NP-1:0] exp_h;
    exp_h = ref_hits(n);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) idle_noise();
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i];
      in_sof = (i == 0); in_eof = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(hit_vec == exp_h, {tag, " R4 hits"}, 32'(hit_vec), 32'(exp_h));
    chk(wake_pulse == (|exp_h), {tag, " R5 wake"}, 32'(wake_pulse), 32'(|exp_h));
    @(negedge clk);
    chk(!wake_pulse, {tag, " R5 pulse width"}, 32'(wake_pulse), 0);
    chk(hit_vec == exp_h, {tag, " R4 hold"}, 32'(hit_vec), 32'(exp_h));
  endtask

  task automatic fill_frame(input int n);
    for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) begin mm[p] = '0; ee[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_vec == '0, "R1 reset hits", 32'(hit_vec), 0);
    chk(!wake_pulse, "R1 reset wake", 32'(wake_pulse), 0);
    fill_frame(20);
    send_frame(20, 0, "R1 unprogrammed");

    // R8: zero mask with check value equal to the initial CRC
    wr(0, 4, 32'h0000FFFF);
    // R3: single selected byte at offset 0
    wr(1, 0, 32'h1);
    fill_frame(30);
    ee[1] = ref_crc(1, 30);
    wr(1, 4, {16'h0, ee[1]});
    send_frame(30, 0, "R8 R3 directed");
    chk(hit_vec[0] == 1'b0, "R8 zero mask", 32'(hit_vec[0]), 0);
    chk(hit_vec[1] == 1'b1, "R3 single byte", 32'(hit_vec[1]), 1);

    // R6: coverage limits; writes to short words 2/3 are ignored
    wr(0, 0, 32'h1);
    wr(0, 2, 32'hFFFFFFFF);
    wr(0, 3, 32'hFFFFFFFF);
    wr(2, 3, 32'h80000000);
    fill_frame(200);
    ee[0] = ref_crc(0, 200);
    ee[2] = ref_crc(2, 200);
    wr(0, 4, {16'h0, ee[0]});
    wr(2, 4, {16'h0, ee[2]});
    send_frame(200, 1, "R6 long frame");
    chk(hit_vec[0] && hit_vec[2], "R6 coverage", 32'(hit_vec), 32'b101);

    // R7: frame ends before the mask window
    wr(3, 0, 32'h4);
    wr(3, 3, 32'h10);
    fill_frame(10);
    ee[3] = ref_crc(3, 10);
    wr(3, 4, {16'h0, ee[3]});
    send_frame(10, 0, "R7 short frame");
    chk(hit_vec[3] == 1'b1, "R7 early end", 32'(hit_vec[3]), 1);

    // R9: stray bytes between frames and idle noise change nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 2); in_data = 8'($urandom);
    end
    repeat (2) idle_noise();
    @(negedge clk);
    in_valid = 1'b0;
    chk(hit_vec == ref_hits(10), "R9 stray bytes", 32'(hit_vec), 32'(ref_hits(10)));
    send_frame(10, 1, "R9 after stray");

    // R2: writes to unused words and patterns are ignored
    wr(3, 5, 32'hFFFFFFFF);
    wr(3, 7, 32'h0);
    wr(5, 0, 32'h0);
    wr(7, 4, 32'h0);
    send_frame(10, 0, "R2 unused addresses");
    chk(hit_vec[3] == 1'b1, "R2 map intact", 32'(hit_vec[3]), 1);

    // random frames
    for (int t = 0; t < 60; t++) begin
      int n;
      n = 1 + ($urandom % 200);
      fill_frame(n);
      for (int p = 0; p < NP; p++) begin
        if ($urandom % 3 == 0) begin
          for (int w = 0; w < 4; w++)
            wr(p, w, ($urandom % 5 == 0) ? 32'h0 : ($urandom & $urandom));
        end
        if ($urandom % 2 == 0) wr(p, 4, {16'h0, ref_crc(p, n)});
        else                   wr(p, 4, $urandom);
      end
      send_frame(n, 1, "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule